// File: doc/BRIEF.md
# ATA PIO Strobe Timing Sequencer

This block runs one programmed-I/O transfer on a parallel ATA device bus per host request. The host presents a request carrying the transfer direction, a 5-bit select word (device address plus two active-low chip selects), a flag that picks the register timing set or the data timing set, and 16 bits of write data. The block drives address and chip selects first, then lowers the read or write strobe, then releases it and waits out a recovery time before it reports completion with a one-clock response pulse. Read data is returned on that response.

All timing values are cycle counts supplied by the host: one setup count shared by both sets, and an active, full-cycle and minimum-recovery count for each of the two sets. The active phase can be stretched by the device ready line. The ready line is sampled through a synchronizer, only after a minimum number of strobe-low cycles, and the stretch ends at a hard limit that sets a sticky timeout flag. After a write strobe the data bus stays driven for a few cycles that depend on the PIO mode.

The request side is valid/ready: `req_ready` is high only while the block is idle, and a request is taken on a clock edge where both `req_valid` and `req_ready` are high; the host holds the request fields stable until then. The response side has no back-pressure: `rsp_valid` is a single-cycle pulse and `rsp_rdata` keeps the last read value until the next read completes.

Top module: `ata_pio_sequencer`

## Requirements
- R1: After reset and whenever idle, `req_ready` is 1, both chip selects and both strobes are 1, `ata_dd_oe` is 0, `rsp_valid` is 0 and `timeout_flag` is 0 after reset.
- R2: From the cycle after acceptance until the response, `ata_cs0n` equals select bit 0, `ata_cs1n` equals select bit 1 and `ata_da` equals select bits 4:2; these do not change while a strobe falls (e.g. select 2 = taskfile register 0, select 0x19 = address 6 with CS0N high, CS1N low).
- R3: The setup phase keeps both strobes high for max(t_setup,1) cycles; then a write (req_write=1) lowers only `ata_diown` and a read lowers only `ata_diorn`.
- R4: With `iordy_en`=0 the strobe stays low for max(act,1) cycles, where act/cyc/rec come from the register set when `req_reg`=1 and from the data set when `req_reg`=0.
- R5: With `iordy_en`=1 the strobe stays low at least IORDY_MIN cycles and until the synchronized ready line is seen high; if it never is, the strobe is released after max(act, IORDY_LIMIT) cycles.
- R6: A transfer whose active phase ends at the ready limit sets `timeout_flag`, which stays 1 until reset.
- R7: Recovery (strobes high, chip selects held) lasts max(cyc − actual active cycles (floored at 0), rec, write hold, 1) cycles.
- R8: For writes, `ata_dd_oe` is 1 on every strobe-low cycle and on exactly the first hold cycles of recovery, with `ata_dd_out` equal to the request data; for reads `ata_dd_oe` stays 0.
- R9: The write hold count is 3 for PIO mode 0, 2 for modes 1 and 2, and 1 for modes 3 and above.
- R10: A read returns on `rsp_rdata` the value of `ata_dd_in` in the last strobe-low cycle.
- R11: `rsp_valid` is high for exactly one cycle right after the last recovery cycle, with chip selects already high; `req_ready` is 0 from acceptance until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken this edge if valid |
| req_write | input | 1 | 1 = write transfer, 0 = read |
| req_reg | input | 1 | 1 = register timing set, 0 = data timing set |
| req_sel | input | 5 | Bit 0 CS0N, bit 1 CS1N, bits 4:2 device address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Data captured by the last read |
| t_setup | input | CNT_W | Setup cycles |
| t_reg_act | input | CNT_W | Register set active cycles |
| t_reg_cyc | input | CNT_W | Register set full-cycle count |
| t_reg_rec | input | CNT_W | Register set minimum recovery |
| t_dat_act | input | CNT_W | Data set active cycles |
| t_dat_cyc | input | CNT_W | Data set full-cycle count |
| t_dat_rec | input | CNT_W | Data set minimum recovery |
| pio_mode | input | 3 | PIO mode, picks write hold |
| iordy_en | input | 1 | Honour the device ready line |
| timeout_flag | output | 1 | Sticky ready-timeout flag |
| ata_cs0n | output | 1 | Chip select 0, active low |
| ata_cs1n | output | 1 | Chip select 1, active low |
| ata_da | output | 3 | Device address |
| ata_diorn | output | 1 | Read strobe, active low |
| ata_diown | output | 1 | Write strobe, active low |
| ata_dd_out | output | DATA_W | Data bus drive value |
| ata_dd_oe | output | 1 | Data bus output enable |
| ata_dd_in | input | DATA_W | Data bus input value |
| ata_iordy | input | 1 | Device ready line (asynchronous) |

## Verification
A wrong phase counter or a wrong latched timing value shows up within one transfer as a setup, strobe-low or recovery length that differs from the arithmetic value, so every sweep point measures all three lengths at the pins. A stuck phase state shows as a missing response or a `req_ready` that never returns, caught within the same transfer. Wrong ready-line handling shows as a strobe released before the minimum sample window or a timeout flag that appears or vanishes, visible at the end of the affected transfer; a wrong data path shows as a mismatched `rsp_rdata` or a drive window that is one cycle off.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SETUP   = 2'd1,
    PH_ACTIVE  = 2'd2,
    PH_RECOVER = 2'd3
  } phase_e;

  // Data bus hold cycles after the write strobe rises, by PIO mode.
  function automatic logic [1:0] hold_for_mode(input logic [2:0] mode);
    if (mode == 3'd0)     return 2'd3;
    else if (mode < 3'd3) return 2'd2;
    else                  return 2'd1;
  endfunction

endpackage

// File: rtl/ata_pio_sync.sv
module ata_pio_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else if (STAGES == 1) begin : g_one
      logic s;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s <= 1'b0;
        else        s <= d;
      end
      assign q = s;
    end else begin : g_chain
      logic [STAGES-1:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[STAGES-2:0], d};
      end
      assign q = sr[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/ata_pio_timing_sel.sv
module ata_pio_timing_sel
  import ata_pio_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             use_reg,
  input  logic             is_write,
  input  logic [2:0]       pio_mode,
  input  logic [CNT_W-1:0] reg_act,
  input  logic [CNT_W-1:0] reg_cyc,
  input  logic [CNT_W-1:0] reg_rec,
  input  logic [CNT_W-1:0] dat_act,
  input  logic [CNT_W-1:0] dat_cyc,
  input  logic [CNT_W-1:0] dat_rec,
  output logic [CNT_W-1:0] act,
  output logic [CNT_W-1:0] cyc,
  output logic [CNT_W-1:0] rec,
  output logic [1:0]       hold
);
  always_comb begin
    if (use_reg) begin
      act = reg_act;
      cyc = reg_cyc;
      rec = reg_rec;
    end else begin
      act = dat_act;
      cyc = dat_cyc;
      rec = dat_rec;
    end
    hold = is_write ? hold_for_mode(pio_mode) : 2'd0;
  end
endmodule

// File: rtl/ata_pio_engine.sv
module ata_pio_engine
  import ata_pio_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CNT_W       = 8,
  parameter int ACT_W       = 11,
  parameter int IORDY_MIN   = 9,
  parameter int IORDY_LIMIT = 322
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [4:0]        req_sel,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [CNT_W-1:0]  t_setup,
  input  logic [CNT_W-1:0]  sel_act,
  input  logic [CNT_W-1:0]  sel_cyc,
  input  logic [CNT_W-1:0]  sel_rec,
  input  logic [1:0]        sel_hold,
  input  logic              iordy_en,
  input  logic              iordy_s,
  input  logic [DATA_W-1:0] dd_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              timeout_flag,
  output logic              cs0n,
  output logic              cs1n,
  output logic [2:0]        da,
  output logic              diorn,
  output logic              diown,
  output logic [DATA_W-1:0] dd_out,
  output logic              dd_oe
);
  phase_e             phase;
  logic [ACT_W-1:0]   cnt;
  logic [ACT_W-1:0]   rec_len;
  logic [CNT_W-1:0]   setup_q, act_q, cyc_q, rec_q;
  logic [1:0]         hold_q;
  logic               write_q, rdy_en_q;
  logic [4:0]         sel_q;
  logic [DATA_W-1:0]  wdata_q;

  logic               accept, setup_end, rdy_ok, limit_hit, act_exit, rec_end;
  logic [ACT_W-1:0]   remain, rec_need;

  assign accept = req_valid && (phase == PH_IDLE);

  always_comb begin
    setup_end = cnt >= ACT_W'(setup_q);
    rdy_ok    = !rdy_en_q || ((cnt >= ACT_W'(IORDY_MIN)) && iordy_s);
    limit_hit = rdy_en_q && (cnt >= ACT_W'(IORDY_LIMIT));
    act_exit  = (cnt >= ACT_W'(act_q)) && (rdy_ok || limit_hit);
    rec_end   = cnt >= rec_len;
    if (ACT_W'(cyc_q) > cnt) remain = ACT_W'(cyc_q) - cnt;
    else                     remain = '0;
    rec_need = remain;
    if (ACT_W'(rec_q) > rec_need)  rec_need = ACT_W'(rec_q);
    if (ACT_W'(hold_q) > rec_need) rec_need = ACT_W'(hold_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase        <= PH_IDLE;
      cnt          <= '0;
      rec_len      <= '0;
      setup_q      <= '0;
      act_q        <= '0;
      cyc_q        <= '0;
      rec_q        <= '0;
      hold_q       <= '0;
      write_q      <= 1'b0;
      rdy_en_q     <= 1'b0;
      sel_q        <= 5'h03;
      wdata_q      <= '0;
      rsp_valid    <= 1'b0;
      rsp_rdata    <= '0;
      timeout_flag <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (accept) begin
            phase    <= PH_SETUP;
            cnt      <= ACT_W'(1);
            setup_q  <= t_setup;
            act_q    <= sel_act;
            cyc_q    <= sel_cyc;
            rec_q    <= sel_rec;
            hold_q   <= sel_hold;
            write_q  <= req_write;
            rdy_en_q <= iordy_en;
            sel_q    <= req_sel;
            wdata_q  <= req_wdata;
          end
        end
        PH_SETUP: begin
          if (setup_end) begin
            phase <= PH_ACTIVE;
            cnt   <= ACT_W'(1);
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_ACTIVE: begin
          if (act_exit) begin
            phase   <= PH_RECOVER;
            cnt     <= ACT_W'(1);
            rec_len <= rec_need;
            if (!write_q) rsp_rdata <= dd_in;
            if (!rdy_ok)  timeout_flag <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_RECOVER: begin
          if (rec_end) begin
            phase     <= PH_IDLE;
            rsp_valid <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  logic busy;
  assign busy      = phase != PH_IDLE;
  assign req_ready = !busy;
  assign cs0n      = busy ? sel_q[0] : 1'b1;
  assign cs1n      = busy ? sel_q[1] : 1'b1;
  assign da        = busy ? sel_q[4:2] : 3'd0;
  assign diorn     = !((phase == PH_ACTIVE) && !write_q);
  assign diown     = !((phase == PH_ACTIVE) && write_q);
  assign dd_out    = wdata_q;
  assign dd_oe     = write_q && ((phase == PH_ACTIVE) ||
                                 ((phase == PH_RECOVER) && (cnt <= ACT_W'(hold_q))));
endmodule

// File: rtl/ata_pio_sequencer.sv
module ata_pio_sequencer #(
  parameter int DATA_W      = 16,
  parameter int CNT_W       = 8,
  parameter int IORDY_MIN   = 9,
  parameter int IORDY_LIMIT = 322,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_reg,
  input  logic [4:0]        req_sel,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [CNT_W-1:0]  t_setup,
  input  logic [CNT_W-1:0]  t_reg_act,
  input  logic [CNT_W-1:0]  t_reg_cyc,
  input  logic [CNT_W-1:0]  t_reg_rec,
  input  logic [CNT_W-1:0]  t_dat_act,
  input  logic [CNT_W-1:0]  t_dat_cyc,
  input  logic [CNT_W-1:0]  t_dat_rec,
  input  logic [2:0]        pio_mode,
  input  logic              iordy_en,
  output logic              timeout_flag,
  output logic              ata_cs0n,
  output logic              ata_cs1n,
  output logic [2:0]        ata_da,
  output logic              ata_diorn,
  output logic              ata_diown,
  output logic [DATA_W-1:0] ata_dd_out,
  output logic              ata_dd_oe,
  input  logic [DATA_W-1:0] ata_dd_in,
  input  logic              ata_iordy
);
  localparam int ACT_W = $clog2(IORDY_LIMIT + (1 << CNT_W)) + 1;

  logic             iordy_s;
  logic [CNT_W-1:0] sel_act, sel_cyc, sel_rec;
  logic [1:0]       sel_hold;

  ata_pio_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst_n (rst_n),
    .d   (ata_iordy),
    .q   (iordy_s)
  );

  ata_pio_timing_sel #(.CNT_W(CNT_W)) tsel_i (
    .use_reg  (req_reg),
    .is_write (req_write),
    .pio_mode (pio_mode),
    .reg_act  (t_reg_act),
    .reg_cyc  (t_reg_cyc),
    .reg_rec  (t_reg_rec),
    .dat_act  (t_dat_act),
    .dat_cyc  (t_dat_cyc),
    .dat_rec  (t_dat_rec),
    .act      (sel_act),
    .cyc      (sel_cyc),
    .rec      (sel_rec),
    .hold     (sel_hold)
  );

  ata_pio_engine #(
    .DATA_W      (DATA_W),
    .CNT_W       (CNT_W),
    .ACT_W       (ACT_W),
    .IORDY_MIN   (IORDY_MIN),
    .IORDY_LIMIT (IORDY_LIMIT)
  ) eng_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_write    (req_write),
    .req_sel      (req_sel),
    .req_wdata    (req_wdata),
    .t_setup      (t_setup),
    .sel_act      (sel_act),
    .sel_cyc      (sel_cyc),
    .sel_rec      (sel_rec),
    .sel_hold     (sel_hold),
    .iordy_en     (iordy_en),
    .iordy_s      (iordy_s),
    .dd_in        (ata_dd_in),
    .rsp_valid    (rsp_valid),
    .rsp_rdata    (rsp_rdata),
    .timeout_flag (timeout_flag),
    .cs0n         (ata_cs0n),
    .cs1n         (ata_cs1n),
    .da           (ata_da),
    .diorn        (ata_diorn),
    .diown        (ata_diown),
    .dd_out       (ata_dd_out),
    .dd_oe        (ata_dd_oe)
  );
endmodule

// File: rtl/ata_pio_checker.sv
module ata_pio_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       timeout_flag,
  input logic       ata_cs0n,
  input logic       ata_cs1n,
  input logic [2:0] ata_da,
  input logic       ata_diorn,
  input logic       ata_diown,
  input logic       ata_dd_oe
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ata_cs0n && ata_cs1n && ata_diorn && ata_diown && !ata_dd_oe));

  assert_addr_before_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ata_diorn) || $fell(ata_diown)) |->
      ($stable(ata_da) && $stable(ata_cs0n) && $stable(ata_cs1n)));

  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ata_diorn && !ata_diown));

  assert_no_drive_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ata_dd_oe |-> ata_diorn);

  assert_drive_with_wstrobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ata_diown |-> ata_dd_oe);

  assert_timeout_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_flag |=> timeout_flag);

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_done_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);
endmodule

bind ata_pio_sequencer ata_pio_checker chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .rsp_valid    (rsp_valid),
  .timeout_flag (timeout_flag),
  .ata_cs0n     (ata_cs0n),
  .ata_cs1n     (ata_cs1n),
  .ata_da       (ata_da),
  .ata_diorn    (ata_diorn),
  .ata_diown    (ata_diown),
  .ata_dd_oe    (ata_dd_oe)
);

// File: tb/ata_pio_sequencer_tb.sv
module ata_pio_sequencer_tb_top;
  localparam int DW   = 16;
  localparam int CW   = 8;
  localparam int IMIN = 9;
  localparam int ILIM = 322;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0, req_reg = 1'b0;
  logic [4:0]    req_sel = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [CW-1:0] t_setup = '0, t_reg_act = '0, t_reg_cyc = '0, t_reg_rec = '0;
  logic [CW-1:0] t_dat_act = '0, t_dat_cyc = '0, t_dat_rec = '0;
  logic [2:0]    pio_mode = '0;
  logic          iordy_en = 1'b0;
  logic [DW-1:0] ata_dd_in = '0;
  logic          ata_iordy = 1'b1;
  logic          req_ready, rsp_valid, timeout_flag;
  logic [DW-1:0] rsp_rdata, ata_dd_out;
  logic          ata_cs0n, ata_cs1n, ata_diorn, ata_diown, ata_dd_oe;
  logic [2:0]    ata_da;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ata_pio_sequencer #(.DATA_W(DW), .CNT_W(CW), .IORDY_MIN(IMIN), .IORDY_LIMIT(ILIM),
                      .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_reg(req_reg), .req_sel(req_sel), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .t_setup(t_setup),
    .t_reg_act(t_reg_act), .t_reg_cyc(t_reg_cyc), .t_reg_rec(t_reg_rec),
    .t_dat_act(t_dat_act), .t_dat_cyc(t_dat_cyc), .t_dat_rec(t_dat_rec),
    .pio_mode(pio_mode), .iordy_en(iordy_en), .timeout_flag(timeout_flag),
    .ata_cs0n(ata_cs0n), .ata_cs1n(ata_cs1n), .ata_da(ata_da), .ata_diorn(ata_diorn),
    .ata_diown(ata_diown), .ata_dd_out(ata_dd_out), .ata_dd_oe(ata_dd_oe),
    .ata_dd_in(ata_dd_in), .ata_iordy(ata_iordy)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int hold_exp(input int mode);
    if (mode == 0) return 3;
    if (mode < 3)  return 2;
    return 1;
  endfunction

  // iordy_mode: 0 = ignore ready, 1 = ready high, 2 = ready low forever,
  // 3 = ready low, raised after 'rel' strobe-low cycles
  task automatic run_txn(input bit wr, input bit rg, input logic [4:0] sel,
                         input logic [DW-1:0] wd, input int su_t, input int act_t,
                         input int cyc_t, input int rec_t, input int mode,
                         input int iordy_mode, input int rel);
    int su = 0, ac = 0, rc = 0, oe_rc = 0, badsel = 0, badstb = 0, baddat = 0;
    int guard = 0, exp_ac, exp_rc, hold;
    bit in_act = 0;
    logic [DW-1:0] last_in = '0;
    @(negedge clk);
    req_write = wr; req_reg = rg; req_sel = sel; req_wdata = wd;
    t_setup = CW'(su_t); pio_mode = 3'(mode);
    iordy_en = (iordy_mode != 0);
    ata_iordy = (iordy_mode == 0 || iordy_mode == 1);
    if (rg) begin
      t_reg_act = CW'(act_t); t_reg_cyc = CW'(cyc_t); t_reg_rec = CW'(rec_t);
      t_dat_act = CW'(act_t + 5); t_dat_cyc = CW'(cyc_t + 7); t_dat_rec = CW'(rec_t + 2);
    end else begin
      t_dat_act = CW'(act_t); t_dat_cyc = CW'(cyc_t); t_dat_rec = CW'(rec_t);
      t_reg_act = CW'(act_t + 5); t_reg_cyc = CW'(cyc_t + 7); t_reg_rec = CW'(rec_t + 2);
    end
    req_valid = 1'b1;
    check("R11 ready before request", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid && guard < 2000) begin
      ata_dd_in = DW'(16'hA5C3 ^ (guard * 37));
      if (ata_cs0n != sel[0] || ata_cs1n != sel[1] || ata_da != sel[4:2] || req_ready)
        badsel++;
      if (wr ? !ata_diorn : !ata_diown) badstb++;
      if (!wr && ata_dd_oe) baddat++;
      if (wr ? !ata_diown : !ata_diorn) begin
        in_act = 1;
        ac++;
        last_in = ata_dd_in;
        if (wr && (!ata_dd_oe || ata_dd_out != wd)) baddat++;
        if (iordy_mode == 3 && ac == rel) ata_iordy = 1'b1;
      end else if (!in_act) begin
        su++;
      end else begin
        rc++;
        if (ata_dd_oe) begin
          oe_rc++;
          if (ata_dd_out != wd) baddat++;
        end
      end
      @(negedge clk);
      guard++;
    end
    hold = wr ? hold_exp(mode) : 0;
    check("R11 response seen", rsp_valid, 1);
    check("R11 chip selects released at response", {ata_cs0n, ata_cs1n}, 2'b11);
    check("R2 select/ready during transfer", badsel, 0);
    check("R3 setup cycles", su, imax(su_t, 1));
    check("R3 wrong strobe", badstb, 0);
    case (iordy_mode)
      0: exp_ac = imax(act_t, 1);
      1: exp_ac = imax(imax(act_t, 1), IMIN);
      2: exp_ac = imax(act_t, ILIM);
      default: exp_ac = -1;
    endcase
    if (iordy_mode == 3) begin
      check("R5 ready release lower bound", (ac >= rel + 1), 1);
      check("R5 ready release upper bound", (ac <= rel + 4), 1);
    end else if (iordy_mode == 0) begin
      check("R4 active cycles", ac, exp_ac);
    end else begin
      check("R5 active cycles with ready", ac, exp_ac);
    end
    exp_rc = imax(imax(imax((cyc_t > ac) ? cyc_t - ac : 0, rec_t), hold), 1);
    check("R7 recovery cycles", rc, exp_rc);
    check("R8 drive window after strobe (R9 hold)", oe_rc, hold);
    check("R8 data drive", baddat, 0);
    if (!wr) check("R10 read data", rsp_rdata, last_in);
    @(negedge clk);
    check("R11 one-cycle done", rsp_valid, 0);
    ata_iordy = 1'b1;
  endtask

  initial begin
    int su_l[2]  = '{0, 2};
    int act_l[2] = '{1, 3};
    int cyc_l[3] = '{0, 5, 9};
    int rec_l[2] = '{0, 2};
    int idx = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset ready", req_ready, 1);
    check("R1 reset selects/strobes", {ata_cs0n, ata_cs1n, ata_diorn, ata_diown}, 4'hF);
    check("R1 reset drive", ata_dd_oe, 0);
    check("R1 reset done", rsp_valid, 0);
    check("R1 reset timeout", timeout_flag, 0);

    for (int w = 0; w < 2; w++)
      for (int r = 0; r < 2; r++)
        for (int a = 0; a < 2; a++)
          for (int b = 0; b < 2; b++)
            for (int c = 0; c < 3; c++)
              for (int d = 0; d < 2; d++)
                for (int m = 0; m < 6; m++) begin
                  logic [4:0] sel;
                  sel = (idx % 3 == 0) ? 5'h19 : {3'(idx % 8), 2'b10};
                  run_txn(w[0], r[0], sel, DW'(16'h1234 ^ (idx * 97)), su_l[a], act_l[b],
                          cyc_l[c], rec_l[d], m, 0, 0);
                  idx++;
                end
    check("R6 no timeout without ready use", timeout_flag, 0);

    run_txn(1'b0, 1'b1, 5'h1e, 16'h0, 1, 2, 4, 1, 4, 1, 0);
    run_txn(1'b1, 1'b0, 5'h02, 16'hBEEF, 1, 12, 20, 1, 0, 1, 0);
    check("R6 no timeout when ready high", timeout_flag, 0);
    run_txn(1'b0, 1'b1, 5'h0a, 16'h0, 0, 3, 4, 2, 3, 2, 0);
    check("R6 timeout set at limit", timeout_flag, 1);
    run_txn(1'b1, 1'b1, 5'h19, 16'h5A5A, 1, 2, 30, 1, 1, 3, 20);
    check("R6 timeout sticky", timeout_flag, 1);

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 timeout cleared by reset", timeout_flag, 0);
    check("R1 idle after reset", req_ready, 1);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(4 * 190000);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule